// File: doc/BRIEF.md
# Crossbar Port Message Forwarder

This block is the per-port engine of a small crossbar switch. It pulls 32-bit words from an inbound first-word-fall-through FIFO and finds the start of each message. Each word carries a side-band control flag, and a set flag marks a frame boundary. The block decodes the target port and the command from the opening word. It then asks the crossbar for a path by raising a request together with a port index. Words are pushed into the outbound FIFO that the crossbar connects, but only in cycles when the path is granted and that FIFO has room.

A point-to-point message goes to one port, from its opening word through its closing word. For a broadcast, every word is copied to each of the other ports before the next word is fetched. The index steps upward from the port's own number and wraps around, so the sender never receives its own message. When the closing word has been handed over, the request falls and the block waits for the next message.

Top module: `msg_port_fwd`

## Requirements
- R1: During and just after synchronous reset, `req`, `in_rd` and `out_wr` are low.
- R2: While idle, the block pops the inbound FIFO's front word as soon as `in_has_data` is high. A popped word with control flag 1 and bit 0 equal to 0 opens a message. Any other word popped while idle is discarded and produces no output.
- R3: The target index is the 4-bit field at bits 4:1 of the opening word, taken modulo the port count. With four ports this is the low two bits, so field 4'b1111 selects port 3. The command is the 4-bit field at bits 12:9.
- R4: From the first forwarded word until the closing word has been forwarded, `req` stays high. Every write occurs with `dest` equal to the receiving port.
- R5: A word is written only in a cycle where `permit` is high and `out_full` is low. Words leave in arrival order, and each keeps its 32 data bits and its control flag.
- R6: A word with control flag 1 and bit 0 equal to 1 closes a message. After its last copy is written, `req` is low in the next cycle and the block accepts a new message.
- R7: While a word waits for `permit` or for space in the outbound FIFO, no further inbound word is popped and the pending word stays on `out_data`/`out_ctrl` unchanged.
- R8: Command value 2 is a broadcast. Each word, including the opening and closing words, is written once to every port except this one, in the order own index+1, own index+2 and so on, modulo the port count. The next word is popped only after all copies of the current one are written.
- R9: Any command value other than 2 (1 included) is forwarded point-to-point to the decoded target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Front word of the inbound FIFO |
| in_ctrl | input | 1 | Control flag of the front word |
| in_has_data | input | 1 | Inbound FIFO is not empty |
| in_rd | output | 1 | Pop strobe for the inbound FIFO |
| out_data | output | 32 | Word presented to the outbound FIFO |
| out_ctrl | output | 1 | Control flag presented with the word |
| out_wr | output | 1 | Write strobe for the outbound FIFO |
| out_full | input | 1 | Outbound FIFO cannot accept a word |
| req | output | 1 | Path request to the crossbar |
| dest | output | 2 | Index of the requested port |
| permit | input | 1 | Crossbar grant for the requested path |

## Verification
The assertions assume the inbound FIFO has first-word-fall-through behaviour. They also assume that `in_data` and `in_ctrl` describe a valid word whenever `in_has_data` is high, and that a popped word is gone in the next cycle. The bench models that FIFO with a queue, so it pops only on a sampled `in_rd` and always presents the current front word. `permit` and `out_full` are treated as arbitrary inputs, and the stimulus toggles them freely, including withholding the grant for long stretches, because the block must tolerate any grant pattern.

// File: rtl/msg_fwd_pkg.sv
package msg_fwd_pkg;

    localparam int WORD_W    = 32;
    localparam int FIELD_W   = 4;
    localparam int DEST_LSB  = 1;
    localparam int CMD_LSB   = 9;

    localparam logic [FIELD_W-1:0] CMD_UNICAST = 4'h1;
    localparam logic [FIELD_W-1:0] CMD_BCAST   = 4'h2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HDR,
        ST_EXTRACT,
        ST_RD_DATA,
        ST_SEND
    } fwd_state_e;

    typedef struct packed {
        logic              ctrl;
        logic [WORD_W-1:0] data;
    } fifo_word_t;

    function automatic logic is_open(input fifo_word_t w);
        return w.ctrl && !w.data[0];
    endfunction

    function automatic logic is_close(input fifo_word_t w);
        return w.ctrl && w.data[0];
    endfunction

endpackage

// File: rtl/msg_hdr_decode.sv
module msg_hdr_decode
    import msg_fwd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DIW    = 2
) (
    input  logic [FIELD_W-1:0] dest_field,
    input  logic [FIELD_W-1:0] cmd_field,
    output logic [DIW-1:0]     dest_idx,
    output logic               bcast
);

    // target index wraps onto the available ports
    always_comb begin
        dest_idx = DIW'(int'(dest_field) % NPORTS);
        bcast    = (cmd_field == CMD_BCAST);
    end

endmodule

// File: rtl/msg_dest_ring.sv
module msg_dest_ring #(
    parameter int NPORTS = 4,
    parameter int DIW    = 2,
    parameter int SELF   = 0
) (
    input  logic [DIW-1:0] cur,
    output logic [DIW-1:0] nxt
);

    // first index after cur, wrapping, that is not this port
    always_comb begin
        logic found;
        int   cand;
        nxt   = cur;
        found = 1'b0;
        for (int k = 1; k < NPORTS; k++) begin
            cand = (int'(cur) + k) % NPORTS;
            if (!found && cand != SELF) begin
                nxt   = DIW'(cand);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msg_port_fwd.sv
module msg_port_fwd
    import msg_fwd_pkg::*;
#(
    parameter int NPORTS  = 4,
    parameter int PORT_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_ctrl,
    input  logic              in_has_data,
    output logic              in_rd,
    output logic [WORD_W-1:0] out_data,
    output logic              out_ctrl,
    output logic              out_wr,
    input  logic              out_full,
    output logic              req,
    output logic [1:0]        dest,
    input  logic              permit
);

    localparam int DIW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam logic [NPORTS-1:0] SELF_BIT = NPORTS'(1) << PORT_ID;
    localparam logic [NPORTS-1:0] ALL_BITS = '1;

    fwd_state_e       state;
    fifo_word_t       hold;
    fifo_word_t       front;
    logic [DIW-1:0]   dest_r;
    logic             bcast_r;
    logic [NPORTS-1:0] sent_mask;

    logic [DIW-1:0]   dec_dest;
    logic             dec_bcast;
    logic [DIW-1:0]   ring_cur;
    logic [DIW-1:0]   ring_nxt;
    logic [NPORTS-1:0] sent_next;
    logic             last_copy;
    logic             fire;

    assign front = '{ctrl: in_ctrl, data: in_data};

    msg_hdr_decode #(.NPORTS(NPORTS), .DIW(DIW)) u_dec (
        .dest_field (hold.data[DEST_LSB +: FIELD_W]),
        .cmd_field  (hold.data[CMD_LSB  +: FIELD_W]),
        .dest_idx   (dec_dest),
        .bcast      (dec_bcast)
    );

    msg_dest_ring #(.NPORTS(NPORTS), .DIW(DIW), .SELF(PORT_ID)) u_ring (
        .cur (ring_cur),
        .nxt (ring_nxt)
    );

    always_comb begin
        fire      = (state == ST_SEND) && permit && !out_full;
        sent_next = sent_mask | (NPORTS'(1) << dest_r);
        last_copy = !bcast_r || ((sent_next | SELF_BIT) == ALL_BITS);
        ring_cur  = (state == ST_SEND && !last_copy) ? dest_r : DIW'(PORT_ID);
        in_rd     = in_has_data && (state == ST_RD_HDR || state == ST_RD_DATA);
        out_wr    = fire;
        out_data  = hold.data;
        out_ctrl  = hold.ctrl;
        req       = (state == ST_SEND) || (state == ST_RD_DATA);
        dest      = 2'(dest_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hold      <= '0;
            dest_r    <= '0;
            bcast_r   <= 1'b0;
            sent_mask <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_has_data) state <= ST_RD_HDR;
                ST_RD_HDR: begin
                    if (in_has_data) begin
                        hold  <= front;
                        state <= is_open(front) ? ST_EXTRACT : ST_IDLE;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_EXTRACT: begin
                    bcast_r   <= dec_bcast;
                    dest_r    <= dec_bcast ? ring_nxt : dec_dest;
                    sent_mask <= '0;
                    state     <= ST_SEND;
                end
                ST_SEND: begin
                    if (fire) begin
                        if (last_copy) begin
                            sent_mask <= '0;
                            if (bcast_r) dest_r <= ring_nxt;
                            state <= is_close(hold) ? ST_IDLE : ST_RD_DATA;
                        end else begin
                            sent_mask <= sent_next;
                            dest_r    <= ring_nxt;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (in_has_data) begin
                        hold  <= front;
                        state <= ST_SEND;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a write only happens into a granted, non-full outbound FIFO
    a_r5_write_needs_grant: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> (permit && !out_full));

    // R2: the pop strobe never fires on an empty inbound FIFO
    a_r2_read_needs_data: assert property (@(posedge clk) disable iff (rst)
        in_rd |-> in_has_data);

    // R7: a stalled word stays put and nothing new is popped
    a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && !out_wr) |=> ($stable(out_data) && $stable(out_ctrl) && !in_rd));

    // R8: a broadcast never targets the sending port
    a_r8_bcast_skips_self: assert property (@(posedge clk) disable iff (rst)
        (req && bcast_r) |-> (dest_r != DIW'(PORT_ID)));

    // R6: request falls once a point-to-point closing word is written
    a_r6_release_after_close: assert property (@(posedge clk) disable iff (rst)
        (out_wr && out_ctrl && out_data[0] && !bcast_r) |=> !req);

    // R4: request is up whenever a word is written
    a_r4_req_on_write: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> req);

endmodule

// File: tb/msg_port_fwd_bench.sv
`timescale 1ns/1ps
module msg_port_fwd_bench;

    localparam int NP   = 4;
    localparam int SELF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_ctrl = 1'b0;
    logic        in_has_data = 1'b0;
    logic        in_rd;
    logic [31:0] out_data;
    logic        out_ctrl;
    logic        out_wr;
    logic        out_full = 1'b0;
    logic        req;
    logic [1:0]  dest;
    logic        permit = 1'b0;

    always #4 clk = ~clk;

    msg_port_fwd #(.NPORTS(NP), .PORT_ID(SELF)) u_msg_port_fwd (
        .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl),
        .in_has_data(in_has_data), .in_rd(in_rd), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_wr(out_wr), .out_full(out_full),
        .req(req), .dest(dest), .permit(permit)
    );

    typedef struct {
        logic [31:0] data;
        logic        ctrl;
        logic [1:0]  dst;
        bit          last;
        int          rq;
    } exp_t;

    logic [32:0] in_q[$];
    exp_t        exp_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    int n_wr  = 0;
    int mode  = 0;   // 0 grant always, 1 random grant/full, 2 grant withheld
    bit pop_now = 0;
    bit in_msg = 0;
    bit expect_idle = 0;
    bit done = 0;

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, expv, $time);
        end
    endtask

    // driver: queue the message words and the writes they must produce
    task automatic push_msg(input logic [3:0] dfield, input logic [3:0] cmd, input int ndata, input int seed);
        logic [32:0] words[$];
        logic [31:0] hdr;
        hdr = (32'(ndata) << 17) | (32'(4'h3) << 13) | (32'(cmd) << 9) | (32'(4'h5) << 5) | (32'(dfield) << 1);
        words.push_back({1'b1, hdr});
        for (int i = 0; i < ndata; i++)
            words.push_back({1'b0, 32'(seed * 32'h9E37) ^ 32'(i * 32'h1111_0101)});
        words.push_back({1'b1, (32'(seed & 'h7ff) << 9) | (32'(SELF) << 1) | 32'h1});
        foreach (words[w]) begin
            in_q.push_back(words[w]);
            if (cmd == 4'h2) begin
                for (int k = 1; k < NP; k++) begin
                    exp_t e;
                    e.data = words[w][31:0]; e.ctrl = words[w][32];
                    e.dst  = 2'((SELF + k) % NP);
                    e.last = (w == words.size() - 1) && (k == NP - 1);
                    e.rq   = 8;
                    exp_q.push_back(e);
                end
            end else begin
                exp_t e;
                e.data = words[w][31:0]; e.ctrl = words[w][32];
                e.dst  = 2'(int'(dfield) % NP);
                e.last = (w == words.size() - 1);
                e.rq   = (cmd == 4'h1) ? 5 : 9;
                exp_q.push_back(e);
            end
        end
    endtask

    // pin driver and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (pop_now) begin void'(in_q.pop_front()); pop_now = 0; end
            in_has_data = (in_q.size() != 0);
            {in_ctrl, in_data} = (in_q.size() != 0) ? in_q[0] : 33'h0;
            case (mode)
                0: begin permit = 1'b1; out_full = 1'b0; end
                1: begin permit = ($urandom % 4) != 0; out_full = ($urandom % 5) == 0; end
                default: begin permit = 1'b0; out_full = 1'b0; end
            endcase
            #3;
            if (!rst) begin
                if (expect_idle) begin
                    check(req == 1'b0, "R6 req after close", 64'(req), 0);
                    expect_idle = 0;
                end
                if (in_msg && !out_wr)
                    check(req == 1'b1, "R4 req mid-message", 64'(req), 1);
                if (in_rd) pop_now = 1;
                if (out_wr) begin
                    n_wr++;
                    check(permit && !out_full, "R5 write without grant", {permit, out_full}, 2'b10);
                    if (exp_q.size() == 0) begin
                        check(0, "R2 unexpected write", 64'(out_data), 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(out_data == e.data && out_ctrl == e.ctrl, $sformatf("R%0d word", e.rq),
                              {out_ctrl, out_data}, {e.ctrl, e.data});
                        check(dest == e.dst, $sformatf("R%0d dest (R3 R4)", e.rq), 64'(dest), 64'(e.dst));
                        check(req == 1'b1, "R4 req at write", 64'(req), 1);
                        in_msg = !e.last;
                        if (e.last) expect_idle = 1;
                    end
                end
            end
        end
    end

    task automatic drain(input string rq);
        int t = 0;
        while ((in_q.size() != 0 || exp_q.size() != 0 || req) && t < 3000) begin
            @(posedge clk); t++;
        end
        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, {rq, " all writes seen"}, 64'(exp_q.size()), 0);
        check(in_q.size() == 0, {rq, " inbound drained"}, 64'(in_q.size()), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #2;
        // R1 reset state
        check(!req && !in_rd && !out_wr, "R1 reset outputs", {req, in_rd, out_wr}, 0);

        // R5 R9 point-to-point with send command, free grant
        mode = 0;
        push_msg(4'h1, 4'h1, 3, 11);
        drain("R5");

        // R3 R9 target field wraps, unknown command, random stalls
        mode = 1;
        push_msg(4'hF, 4'h7, 4, 23);
        drain("R3");

        // R2 stray word while idle is discarded, then a bare message
        in_q.push_back({1'b0, 32'hDEAD_BEE0});
        in_q.push_back({1'b1, 32'h0000_00F1});
        push_msg(4'h0, 4'h1, 0, 37);
        drain("R2");

        // R8 broadcast, random stalls
        push_msg(4'h1, 4'h2, 2, 41);
        drain("R8");

        // R7 grant withheld: only the opening word may be popped
        begin
            int t = 0;
            int wr0;
            mode = 2;
            push_msg(4'h3, 4'h1, 1, 53);
            while (!req && t < 50) begin @(posedge clk); t++; end
            wr0 = n_wr;
            repeat (20) @(posedge clk);
            @(negedge clk); #2;
            check(in_q.size() == 2, "R7 no pop while stalled", 64'(in_q.size()), 2);
            check(n_wr == wr0, "R7 no write while stalled", 64'(n_wr), 64'(wr0));
            check(dest == 2'd3 && req, "R4 request held while stalled", {req, dest}, {1'b1, 2'd3});
            mode = 1;
            drain("R7");
        end

        // back-to-back mix of broadcast and point-to-point
        push_msg(4'h2, 4'h2, 1, 61);
        push_msg(4'h5, 4'h1, 2, 67);
        push_msg(4'h0, 4'h2, 0, 71);
        drain("R8 R6");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule